// File: doc/BRIEF.md
# Memory-to-Stream DMA Read Engine

This block is the read half of a simple DMA engine. It reads a contiguous, 8-byte-aligned buffer from memory through a 64-bit AXI4 read master and sends the bytes out as a 32-bit AXI4-Stream. The stream marks the end of the packet with TLAST and flags the valid bytes of a short final word with TKEEP. A small register write port sets the source address and the byte count. Writing a non-zero byte count while the engine is idle starts a transfer. Two status outputs, busy and done, show the engine's progress. A control write stops a running transfer part-way.

Memory reads are INCR bursts of 8-byte beats. Only one burst is in flight at a time. A burst is never longer than the configured maximum, and it never crosses a 4 KB page. Each 64-bit word passes through a small read-data FIFO, so stream backpressure never loses data. The word is then split into two 32-bit stream beats, lower half first. The byte-count register has a configurable width. A larger request is cut down to the largest count the register can hold.

Top module: `mem_to_stream_dma`

## Requirements
- R1: After reset, busy_o, done_o, m_arvalid_o and st_tvalid_o are all 0.
- R2: A register write with cfg_sel_i = 1 and non-zero data while busy_o is 0 starts a transfer. From the next cycle busy_o is 1 and done_o is 0. A length write of 0, or any length write while busy_o is 1, has no effect.
- R3: A requested length above 2^LEN_W - 1 is cut down to 2^LEN_W - 1 bytes.
- R4: A register write with cfg_sel_i = 0 sets the source address. Its low three bits are ignored, so every read address is 8-byte aligned. Every request uses m_arsize_o = 3 (8-byte beats) and m_arburst_o = 1 (INCR).
- R5: Bursts follow one another in address order. Each burst has min(beats left, MAX_BURST, beats left in the current 4 KB page) beats. Only one burst is outstanding at a time. In total, ceil(len/8) beats are read.
- R6: Stream beat k carries the bytes at source + 4k. Of each 64-bit word, bits 31:0 go out first, then bits 63:32.
- R7: The stream has ceil(len/4) beats. TLAST is set only on the last beat. On every other beat TKEEP is 4'b1111. On the last beat, TKEEP has its low r bits set, where r = len - 4(beats - 1), giving 0001, 0011, 0111 or 1111.
- R8: While st_tvalid_o is 1 and st_tready_i is 0, the stream beat stays valid and unchanged. No beat is lost or duplicated under memory or stream stalls.
- R9: done_o becomes 1, and busy_o becomes 0, in the cycle after the last stream beat is accepted. done_o stays 1 until the next start.
- R10: A register write with cfg_sel_i = 2 and data bit 0 set, while busy_o is 1, stops the transfer. From the next cycle the stream is silent. No new burst is requested beyond one already being offered. Read data still outstanding is accepted and thrown away. busy_o falls once that data has arrived, and done_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 source address, 1 length/start, 2 control |
| cfg_wdata_i | input | 32 | Register write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Last transfer completed |
| m_arvalid_o | output | 1 | Read address valid |
| m_arready_i | input | 1 | Read address ready |
| m_araddr_o | output | ADDR_W | Read burst start address |
| m_arlen_o | output | 8 | Burst beats minus one |
| m_arsize_o | output | 3 | Beat size code (3 = 8 bytes) |
| m_arburst_o | output | 2 | Burst type (1 = INCR) |
| m_rvalid_i | input | 1 | Read data valid |
| m_rready_o | output | 1 | Read data ready |
| m_rdata_i | input | 64 | Read data |
| m_rlast_i | input | 1 | Last beat of burst |
| st_tvalid_o | output | 1 | Stream beat valid |
| st_tready_i | input | 1 | Stream consumer ready |
| st_tdata_o | output | 32 | Stream data |
| st_tkeep_o | output | 4 | Stream byte enables |
| st_tlast_o | output | 1 | End of packet |

## Verification
The bench sweeps every short length from 1 to 24 bytes, so all four TKEEP patterns appear and the packet ends in both the lower and the upper half of a word. A design that counted ends wrongly would emit a stray beat, or drop the last one. Start addresses close to a 4 KB page show whether bursts are trimmed to the page: an engine that ignored the page would ask for one over-long burst. Oversized length requests check the cut-down to 4095 bytes, where a truncating design would wrap to a short count. Random stalls on both channels, a length write while busy and a stop in mid-transfer followed by a fresh transfer are also run. An engine that failed to flush after a stop would leak old data into the next packet.

// File: rtl/m2s_dma_pkg.sv
package m2s_dma_pkg;
  typedef enum logic [1:0] {
    AR_IDLE,
    AR_REQ,
    AR_WAIT
  } ar_state_e;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_LEN  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [2:0] SIZE_8B    = 3'b011;
endpackage

// File: rtl/m2s_cfg_regs.sv
module m2s_cfg_regs
  import m2s_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        sel_i,
  input  logic [31:0]       wdata_i,
  input  logic              busy_i,
  input  logic              final_fire_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              done_o
);
  localparam logic [31:0] LEN_MAX = 32'((64'd1 << LEN_W) - 64'd1);

  logic [ADDR_W-1:0] src_q;
  logic              done_q;

  assign start_o = we_i && (sel_i == SEL_LEN) && (wdata_i != 32'd0) && !busy_i;
  assign stop_o  = we_i && (sel_i == SEL_CTRL) && wdata_i[0] && busy_i;
  // oversize requests saturate
  assign len_o   = (wdata_i > LEN_MAX) ? LEN_MAX[LEN_W-1:0] : wdata_i[LEN_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (we_i && (sel_i == SEL_SRC)) src_q <= {wdata_i[ADDR_W-1:3], 3'b000};
      if (start_o)           done_q <= 1'b0;
      else if (final_fire_i) done_q <= 1'b1;
    end
  end

  assign src_addr_o = src_q;
  assign done_o     = done_q;
endmodule

// File: rtl/m2s_burst_gen.sv
module m2s_burst_gen
  import m2s_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 14,
  parameter int MAX_BURST  = 16,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              stop_i,
  output logic              arvalid_o,
  input  logic              arready_i,
  output logic [ADDR_W-1:0] araddr_o,
  output logic [7:0]        arlen_o,
  input  logic              rlast_beat_i,
  output logic              busy_o
);
  localparam int PAGE_W     = $clog2(PAGE_BYTES);
  localparam int PAGE_BEATS = PAGE_BYTES / 8;

  ar_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic              stop_q;
  logic [31:0]       room, want, blen;
  logic [LEN_W-1:0]  beats_total;

  assign beats_total = LEN_W'(({1'b0, len_i} + (LEN_W+1)'(7)) >> 3);

  always_comb begin
    room = 32'(PAGE_BEATS) - 32'(addr_q[PAGE_W-1:3]);
    want = (32'(left_q) < 32'(MAX_BURST)) ? 32'(left_q) : 32'(MAX_BURST);
    blen = (want < room) ? want : room;
  end

  assign arvalid_o = (state_q == AR_REQ);
  assign araddr_o  = addr_q;
  assign arlen_o   = 8'(blen - 32'd1);
  assign busy_o    = (state_q != AR_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= AR_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      stop_q  <= 1'b0;
    end else begin
      unique case (state_q)
        AR_IDLE: if (start_i) begin
          addr_q  <= src_addr_i;
          left_q  <= beats_total;
          stop_q  <= 1'b0;
          state_q <= AR_REQ;
        end
        AR_REQ: begin
          if (stop_i) stop_q <= 1'b1;
          // a pending request must complete even when stopping
          if (arready_i) begin
            addr_q  <= addr_q + ADDR_W'(blen << 3);
            left_q  <= left_q - LEN_W'(blen);
            state_q <= AR_WAIT;
          end
        end
        AR_WAIT: begin
          if (stop_i) stop_q <= 1'b1;
          if (rlast_beat_i)
            state_q <= (stop_q || stop_i || left_q == '0) ? AR_IDLE : AR_REQ;
        end
        default: state_q <= AR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/m2s_rd_fifo.sv
module m2s_rd_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [PTR_W:0]   cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == (PTR_W+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + PTR_W'(1);
      if (do_pop)  rd_q <= rd_q + PTR_W'(1);
      unique case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + (PTR_W+1)'(1);
        2'b01:   cnt_q <= cnt_q - (PTR_W+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/m2s_unpack.sv
module m2s_unpack #(
  parameter int LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             flush_i,
  input  logic             word_valid_i,
  input  logic [63:0]      word_i,
  output logic             pop_o,
  output logic             tvalid_o,
  input  logic             tready_i,
  output logic [31:0]      tdata_o,
  output logic [3:0]       tkeep_o,
  output logic             tlast_o,
  output logic             active_o,
  output logic             final_fire_o
);
  logic [LEN_W-1:0] rem_q;
  logic             half_q;
  logic             last, fire;

  assign active_o = (rem_q != '0);
  assign last     = active_o && (rem_q <= LEN_W'(4));
  assign tvalid_o = active_o && word_valid_i;
  assign tdata_o  = half_q ? word_i[63:32] : word_i[31:0];
  assign tlast_o  = last;
  assign fire     = tvalid_o && tready_i;
  assign pop_o    = fire && (last || half_q);
  assign final_fire_o = fire && last;

  always_comb begin
    tkeep_o = 4'b1111;
    if (last) begin
      unique case (rem_q[2:0])
        3'd1:    tkeep_o = 4'b0001;
        3'd2:    tkeep_o = 4'b0011;
        3'd3:    tkeep_o = 4'b0111;
        default: tkeep_o = 4'b1111;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      half_q <= 1'b0;
    end else if (flush_i) begin
      rem_q  <= '0;
      half_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= len_i;
      half_q <= 1'b0;
    end else if (fire) begin
      rem_q  <= last ? '0 : rem_q - LEN_W'(4);
      half_q <= last ? 1'b0 : !half_q;
    end
  end
endmodule

// File: rtl/mem_to_stream_dma.sv
module mem_to_stream_dma
  import m2s_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 14,
  parameter int MAX_BURST  = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              m_arvalid_o,
  input  logic              m_arready_i,
  output logic [ADDR_W-1:0] m_araddr_o,
  output logic [7:0]        m_arlen_o,
  output logic [2:0]        m_arsize_o,
  output logic [1:0]        m_arburst_o,
  input  logic              m_rvalid_i,
  output logic              m_rready_o,
  input  logic [63:0]       m_rdata_i,
  input  logic              m_rlast_i,
  output logic              st_tvalid_o,
  input  logic              st_tready_i,
  output logic [31:0]       st_tdata_o,
  output logic [3:0]        st_tkeep_o,
  output logic              st_tlast_o
);
  logic [ADDR_W-1:0] src_addr;
  logic [LEN_W-1:0]  len;
  logic start, stop, final_fire;
  logic ar_busy, pk_active;
  logic fifo_full, fifo_empty, fifo_pop, fifo_push;
  logic [63:0] fifo_word;
  logic drain_q, rbeat, rlast_beat;

  assign busy_o      = ar_busy || pk_active;
  assign m_arsize_o  = SIZE_8B;
  assign m_arburst_o = BURST_INCR;
  // while draining after a stop, sink returning data unconditionally
  assign m_rready_o  = drain_q || !fifo_full;
  assign rbeat       = m_rvalid_i && m_rready_o;
  assign rlast_beat  = rbeat && m_rlast_i;
  assign fifo_push   = rbeat && !drain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      drain_q <= 1'b0;
    else if (stop)    drain_q <= 1'b1;
    else if (!ar_busy) drain_q <= 1'b0;
  end

  m2s_cfg_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .busy_i(busy_o), .final_fire_i(final_fire),
    .src_addr_o(src_addr), .len_o(len),
    .start_o(start), .stop_o(stop), .done_o(done_o)
  );

  m2s_burst_gen #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST), .PAGE_BYTES(4096)
  ) u_bgen (
    .clk_i, .rst_ni,
    .start_i(start), .src_addr_i(src_addr), .len_i(len), .stop_i(stop),
    .arvalid_o(m_arvalid_o), .arready_i(m_arready_i),
    .araddr_o(m_araddr_o), .arlen_o(m_arlen_o),
    .rlast_beat_i(rlast_beat), .busy_o(ar_busy)
  );

  m2s_rd_fifo #(.WIDTH(64), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i(stop), .push_i(fifo_push), .wdata_i(m_rdata_i),
    .pop_i(fifo_pop), .rdata_o(fifo_word),
    .full_o(fifo_full), .empty_o(fifo_empty)
  );

  m2s_unpack #(.LEN_W(LEN_W)) u_unpack (
    .clk_i, .rst_ni,
    .start_i(start), .len_i(len), .flush_i(stop),
    .word_valid_i(!fifo_empty), .word_i(fifo_word), .pop_o(fifo_pop),
    .tvalid_o(st_tvalid_o), .tready_i(st_tready_i),
    .tdata_o(st_tdata_o), .tkeep_o(st_tkeep_o), .tlast_o(st_tlast_o),
    .active_o(pk_active), .final_fire_o(final_fire)
  );
endmodule

// File: rtl/mem_to_stream_dma_chk.sv
module mem_to_stream_dma_chk #(
  parameter int ADDR_W    = 32,
  parameter int MAX_BURST = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [1:0]        cfg_sel_i,
  input logic [31:0]       cfg_wdata_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              m_arvalid_o,
  input logic              m_arready_i,
  input logic [ADDR_W-1:0] m_araddr_o,
  input logic [7:0]        m_arlen_o,
  input logic [2:0]        m_arsize_o,
  input logic [1:0]        m_arburst_o,
  input logic              st_tvalid_o,
  input logic              st_tready_i,
  input logic [31:0]       st_tdata_o,
  input logic [3:0]        st_tkeep_o,
  input logic              st_tlast_o
);
  logic stop_wr;
  assign stop_wr = cfg_we_i && (cfg_sel_i == 2'd2) && cfg_wdata_i[0];

  p_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_arvalid_o |-> (m_araddr_o[2:0] == 3'd0) && (m_arsize_o == 3'd3) && (m_arburst_o == 2'd1));

  p_ar_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_arvalid_o && !m_arready_i |=> m_arvalid_o && $stable(m_araddr_o) && $stable(m_arlen_o));

  p_burst_max_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_arvalid_o |-> (32'(m_arlen_o) < 32'(MAX_BURST)));

  p_page_cross_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_arvalid_o |-> ({1'b0, m_araddr_o[11:3]} + {2'b00, m_arlen_o}) < 10'd512);

  p_keep_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_tvalid_o && !st_tlast_o |-> st_tkeep_o == 4'b1111);

  p_keep_shape_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_tvalid_o |-> st_tkeep_o inside {4'b0001, 4'b0011, 4'b0111, 4'b1111});

  p_beat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_tvalid_o && !st_tready_i && !stop_wr |=>
      st_tvalid_o && $stable(st_tdata_o) && $stable(st_tkeep_o) && $stable(st_tlast_o));

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !st_tvalid_o);

  p_last_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_tvalid_o && st_tready_i && st_tlast_o |=> done_o);

  p_stop_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_wr && busy_o |=> !st_tvalid_o && !done_o);
endmodule

bind mem_to_stream_dma mem_to_stream_dma_chk #(.ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
  .busy_o(busy_o), .done_o(done_o),
  .m_arvalid_o(m_arvalid_o), .m_arready_i(m_arready_i),
  .m_araddr_o(m_araddr_o), .m_arlen_o(m_arlen_o),
  .m_arsize_o(m_arsize_o), .m_arburst_o(m_arburst_o),
  .st_tvalid_o(st_tvalid_o), .st_tready_i(st_tready_i),
  .st_tdata_o(st_tdata_o), .st_tkeep_o(st_tkeep_o), .st_tlast_o(st_tlast_o)
);

// File: tb/mem_to_stream_dma_tb.sv
module mem_to_stream_dma_tb;
  localparam int LEN_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic busy, done;
  logic arvalid, arready = 1'b0;
  logic [31:0] araddr;
  logic [7:0] arlen;
  logic [2:0] arsize;
  logic [1:0] arburst;
  logic rvalid = 1'b0, rready, rlast = 1'b0;
  logic [63:0] rdata = 64'd0;
  logic tvalid, tready = 1'b0, tlast;
  logic [31:0] tdata;
  logic [3:0] tkeep;

  always #5 clk = !clk;

  mem_to_stream_dma #(.LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .busy_o(busy), .done_o(done),
    .m_arvalid_o(arvalid), .m_arready_i(arready), .m_araddr_o(araddr),
    .m_arlen_o(arlen), .m_arsize_o(arsize), .m_arburst_o(arburst),
    .m_rvalid_i(rvalid), .m_rready_o(rready), .m_rdata_i(rdata), .m_rlast_i(rlast),
    .st_tvalid_o(tvalid), .st_tready_i(tready), .st_tdata_o(tdata),
    .st_tkeep_o(tkeep), .st_tlast_o(tlast)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit bp_on = 0, hold_skip = 0, stopped = 0;
  logic [31:0] exp_base = 0, ar_next = 0, mem_addr = 0;
  int exp_len = 0, exp_beats = 0, beat_idx = 0, ar_rem = 0, ar_total = 0, mem_left = 0;
  bit rv_hold = 0;
  bit p_tv = 0, p_tr = 0, p_tl = 0;
  logic [31:0] p_td = 0;
  logic [3:0] p_tk = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus models: all decisions made at the falling edge for the next rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (p_tv && !p_tr && !hold_skip)
        check(tvalid && tdata == p_td && tkeep == p_tk && tlast == p_tl,
              "R8", "stalled beat changed", {tvalid, tdata}, {1'b1, p_td});
      if (stopped && tvalid) check(0, "R10", "stream active after stop", 1, 0);
      tready = bp_on ? (lfsr[0] | lfsr[3]) : 1'b1;
      if (tvalid && tready) begin
        if (beat_idx >= exp_beats) check(0, "R7", "extra stream beat", beat_idx, exp_beats);
        else begin
          int rb;
          logic el;
          logic [3:0] ek;
          rb = exp_len - 4 * beat_idx;
          el = (beat_idx == exp_beats - 1);
          ek = (!el || rb >= 4) ? 4'hF : 4'((1 << rb) - 1);
          check(tdata == exp_base + 32'(4 * beat_idx), "R6", "tdata", tdata,
                exp_base + 32'(4 * beat_idx));
          check(tkeep == ek && tlast == el, "R7", "keep/last", {tkeep, tlast}, {ek, el});
        end
        beat_idx++;
      end
      p_tv = tvalid; p_tr = tready; p_td = tdata; p_tk = tkeep; p_tl = tlast;

      if (mem_left > 0) begin
        if (!rv_hold) rvalid = bp_on ? lfsr[5] : 1'b1;
        rdata = {mem_addr + 32'd4, mem_addr};
        rlast = (mem_left == 1);
        if (rvalid && rready) begin
          mem_addr = mem_addr + 32'd8;
          mem_left--;
          rv_hold = 0;
        end else rv_hold = rvalid;
      end else begin
        rvalid = 1'b0; rlast = 1'b0; rv_hold = 0;
      end

      arready = bp_on ? lfsr[7] : 1'b1;
      if (arvalid && arready) begin
        int room, want;
        room = 512 - int'((araddr & 32'hFFF) >> 3);
        want = (ar_rem < 16) ? ar_rem : 16;
        if (room < want) want = room;
        check(mem_left == 0, "R5", "second burst outstanding", mem_left, 0);
        check(araddr == ar_next, "R5", "burst address", araddr, ar_next);
        check(int'(arlen) == want - 1, "R5", "burst length", arlen, want - 1);
        check(arsize == 3'd3 && arburst == 2'd1 && araddr[2:0] == 3'd0, "R4",
              "size/burst/align", {arsize, arburst, araddr[2:0]}, {3'd3, 2'd1, 3'd0});
        ar_next = ar_next + 32'(want * 8);
        ar_rem -= want;
        ar_total += want;
        mem_addr = araddr;
        mem_left = int'(arlen) + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: cycle %0d exceeds limit", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [31:0] addr, input int len, input bit bp);
    exp_base = addr & ~32'd7; exp_len = len; exp_beats = (len + 3) / 4; beat_idx = 0;
    ar_next = exp_base; ar_rem = (len + 7) / 8; ar_total = 0;
    bp_on = bp; hold_skip = 0; stopped = 0;
  endtask

  task automatic run_xfer(input logic [31:0] addr, input int req_len, input int len,
                          input bit bp, input bit mid_write);
    int t;
    setup(addr, len, bp);
    cfg_write(2'd0, addr);
    cfg_write(2'd1, 32'(req_len));
    check(busy && !done, "R2", "busy/done after start", {busy, done}, 2'b10);
    if (mid_write) begin
      repeat (5) @(negedge clk);
      cfg_write(2'd1, 32'd8);
      check(busy, "R2", "length write while busy", busy, 1);
    end
    t = 0;
    while (beat_idx < exp_beats && t < 30000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    check(beat_idx == exp_beats, "R7", "stream beat count", beat_idx, exp_beats);
    check(done && !busy, "R9", "done/busy after last beat", {done, busy}, 2'b10);
    check(ar_total == (len + 7) / 8 && mem_left == 0, "R5", "memory beats read",
          ar_total, (len + 7) / 8);
    repeat (2) @(negedge clk);
    check(done && !tvalid && !arvalid, "R9", "done held", {done, tvalid, arvalid}, 3'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !arvalid && !tvalid, "R1", "reset outputs",
          {busy, done, arvalid, tvalid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !arvalid && !tvalid, "R1", "after release",
          {busy, done, arvalid, tvalid}, 0);

    cfg_write(2'd1, 32'd0);
    @(negedge clk);
    check(!busy && !arvalid, "R2", "zero length ignored", {busy, arvalid}, 0);

    for (int l = 1; l <= 24; l++) run_xfer(32'h1000 + 32'(l * 256), l, l, l[0], 0);
    // zero length after completion leaves done set
    cfg_write(2'd1, 32'd0);
    @(negedge clk);
    check(done && !busy, "R2", "zero length keeps done", {done, busy}, 2'b10);

    run_xfer(32'h0000_2005, 13, 13, 0, 0);     // R4 unaligned source
    run_xfer(32'h0000_0FC0, 200, 200, 1, 0);   // R5 page trim
    run_xfer(32'h0000_3FF8, 64, 64, 0, 0);     // R5 one beat before page
    run_xfer(32'h0001_0000, 400, 400, 1, 1);   // R2 write while busy
    run_xfer(32'h0000_8000, 100000, 4095, 1, 0); // R3 clamp
    run_xfer(32'h0002_0000, 4096, 4095, 0, 0);   // R3 one above max
    run_xfer(32'h0003_0000, 4095, 4095, 0, 0);   // R3 exact max

    begin : stop_test
      int t;
      setup(32'h4000, 3000, 1);
      cfg_write(2'd0, 32'h4000);
      cfg_write(2'd1, 32'd3000);
      t = 0;
      while (beat_idx < 20 && t < 5000) begin @(negedge clk); t++; end
      hold_skip = 1;
      cfg_write(2'd2, 32'd1);
      stopped = 1;
      t = 0;
      while (busy && t < 2000) begin @(negedge clk); t++; end
      check(!busy, "R10", "busy falls after stop", busy, 0);
      check(!done, "R10", "done stays clear", done, 0);
      check(mem_left == 0 && !arvalid, "R10", "outstanding drained", mem_left, 0);
      check(beat_idx < exp_beats, "R10", "transfer cut short", beat_idx, exp_beats);
      repeat (20) @(negedge clk);
    end
    run_xfer(32'h0000_5000, 37, 37, 1, 0);     // R10 clean restart

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule